// File: doc/BRIEF.md
# SD Host Status Flag Register

This block holds the 32-bit status word of an SD/MMC host controller. The command engine, the data engine, the FIFO and the DMA path report their conditions to it as single-cycle event pulses or as steady levels. The block keeps one flag per condition and presents the whole word to a simple register-read bus. A one-cycle read strobe copies the word into a held read-data output.

Each flag follows one clear rule, and one word mixes several rules. Some flags clear when the status word is read. Response errors clear when software writes the command register. The receive-ready flag clears when the receive data register is read, and the transmit-ready flag clears when the transmit data register is written. The busy indication clears on the end of a card response. Three bits follow a live level. The overrun and underrun flags use a configuration input to choose between clear-on-read and clear-on-command-write.

The transfer-in-progress bit comes from a small state machine with three states. `DT_IDLE` moves to `DT_DATA` on a transfer start. `DT_DATA` moves to `DT_CRC` when the data phase ends. `DT_CRC` returns to `DT_IDLE` when the CRC16 calculation finishes. The bit is high in `DT_DATA` and in `DT_CRC`. Any other event leaves the state unchanged.

Top module: `sdsr_status_top`

## Requirements
- R1: After reset the status word reads 0x0000_0025: bit 0 (command ready), bit 2 (transmit ready) and bit 5 (not busy) are 1 and every other bit is 0, provided the live levels are low.
- R2: Bit 0 (command ready) clears on `cmd_wr` and sets on `ev_cmd_sent`.
- R3: Bit 1 (receive ready) sets on `ev_rx_data`, is not cleared by a status read, and clears on `rdr_rd`. Bit 2 (transmit ready) clears on `tdr_wr` and sets on `ev_tx_moved`.
- R4: The response error bits are index (bit 16), direction (bit 17), CRC7 (bit 18), end bit (bit 19) and time-out (bit 20), driven by `ev_resp_err[0..4]` in that order. Each one sets on its pulse, survives status reads, and clears only on `cmd_wr`.
- R5: The sticky bits are 3 (block end), 8 (SDIO interrupt), 13 (completion signal), 21 (data CRC error), 22 (data time-out), 23 (completion time-out), 24 (block overrun), 27 (boot acknowledge) and 28 (boot acknowledge error). Each one sets on its pulse and holds until a status read. That read returns 1, and the read after it returns 0.
- R6: With `cfg_err_clr_on_read`=1, bit 30 (overrun) and bit 31 (underrun) clear on a status read and ignore `cmd_wr`. With the input at 0, they clear on `cmd_wr` and ignore status reads.
- R7: Bit 4 (transfer in progress) rises after `ev_xfer_start`. It stays high after `ev_data_end` and falls after `ev_crc_done`. An `ev_crc_done` seen while idle has no effect.
- R8: Bit 5 (not busy) clears on `ev_resp_end` and sets on `ev_busy_end`.
- R9: Bit 12 (`lv_sdio_wait`), bit 25 (`lv_fifo_empty`) and bit 26 (`lv_xfer_idle`) report the level present in the read cycle and are not latched.
- R10: When a set event and a clear of the same flag fall in one cycle, the flag ends up set.
- R11: `rd_data` loads the word in the cycle `rd_stb` is high, which is the value before any clear made by that read. It holds that value until the next strobe.
- R12: Bits 6, 7, 9, 10, 11, 14, 15 and 29 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb | input | 1 | Status word read strobe |
| rd_data | output | 32 | Status word captured by the last read |
| cmd_wr | input | 1 | Command register written |
| rdr_rd | input | 1 | Receive data register read |
| tdr_wr | input | 1 | Transmit data register written |
| cfg_err_clr_on_read | input | 1 | 1: overrun/underrun clear on status read; 0: on command write |
| ev_cmd_sent | input | 1 | Last command sent |
| ev_rx_data | input | 1 | Received data available |
| ev_tx_moved | input | 1 | Transmit data moved to shift register |
| ev_blk_end | input | 1 | Write block ended with CRC status |
| ev_xfer_start | input | 1 | Data transfer started |
| ev_data_end | input | 1 | Data phase ended, CRC16 pending |
| ev_crc_done | input | 1 | CRC16 calculation finished |
| ev_resp_end | input | 1 | Card response ended, busy begins |
| ev_busy_end | input | 1 | Busy on data line ended |
| ev_sdio_irq | input | 1 | SDIO interrupt detected |
| lv_sdio_wait | input | 1 | Data bus in read-wait state (level) |
| ev_cmpl_sig | input | 1 | Command completion signal received |
| ev_resp_err | input | 5 | Response errors: index, direction, CRC7, end bit, time-out |
| ev_data_crc_err | input | 1 | Data CRC16 error |
| ev_data_tout | input | 1 | Data time-out |
| ev_cmpl_tout | input | 1 | Completion signal time-out |
| ev_blk_ovr | input | 1 | DMA block overrun |
| lv_fifo_empty | input | 1 | FIFO empty (level) |
| lv_xfer_idle | input | 1 | Command and data bus idle (level) |
| ev_boot_ack | input | 1 | Boot acknowledge received |
| ev_boot_ack_err | input | 1 | Corrupted boot acknowledge |
| ev_rx_overrun | input | 1 | Received data lost |
| ev_tx_underrun | input | 1 | Data sent without valid content |

## Verification
A flag's set event and its clear can land on the same clock edge. The clear can be a status read, a command-register write or a data-register access. The bench provokes this by raising the event in the same cycle as the read strobe, `cmd_wr` or `rdr_rd`. That read must return the flag's earlier value, and a later read must show the flag set. Overrun and underrun are tested under both settings of the configuration input, with a command write or a status read that must not clear them.

// File: rtl/sdsr_pkg.sv
package sdsr_pkg;

    localparam int SR_W = 32;
    localparam int RESP_ERR_W = 5;

    localparam int B_CMDRDY   = 0;
    localparam int B_RXRDY    = 1;
    localparam int B_TXRDY    = 2;
    localparam int B_BLKEND   = 3;
    localparam int B_XFERBUSY = 4;
    localparam int B_NOTBUSY  = 5;
    localparam int B_SDIOIRQ  = 8;
    localparam int B_SDIOWAIT = 12;
    localparam int B_CMPLSIG  = 13;
    localparam int B_RESPERR  = 16;
    localparam int B_DCRCERR  = 21;
    localparam int B_DTOUT    = 22;
    localparam int B_CTOUT    = 23;
    localparam int B_BLKOVR   = 24;
    localparam int B_FIFOEMP  = 25;
    localparam int B_XFRIDLE  = 26;
    localparam int B_BOOTACK  = 27;
    localparam int B_BOOTERR  = 28;
    localparam int B_OVERRUN  = 30;
    localparam int B_UNDERRUN = 31;

    localparam logic [SR_W-1:0] RESET_WORD =
        (SR_W'(1) << B_CMDRDY) | (SR_W'(1) << B_TXRDY) | (SR_W'(1) << B_NOTBUSY);

    typedef enum logic [3:0] {
        RULE_RSVD,
        RULE_LIVE,
        RULE_ON_READ,
        RULE_ON_CMD,
        RULE_ON_RDR,
        RULE_ON_TDR,
        RULE_BY_CFG,
        RULE_ON_EVT
    } rule_e;

    function automatic rule_e bit_rule(input int b);
        rule_e r;
        r = RULE_RSVD;
        if (b == B_CMDRDY) r = RULE_ON_CMD;
        else if (b == B_RXRDY) r = RULE_ON_RDR;
        else if (b == B_TXRDY) r = RULE_ON_TDR;
        else if (b == B_NOTBUSY) r = RULE_ON_EVT;
        else if (b == B_XFERBUSY || b == B_SDIOWAIT || b == B_FIFOEMP || b == B_XFRIDLE)
            r = RULE_LIVE;
        else if (b >= B_RESPERR && b < B_RESPERR + RESP_ERR_W) r = RULE_ON_CMD;
        else if (b == B_BLKEND || b == B_SDIOIRQ || b == B_CMPLSIG || b == B_DCRCERR ||
                 b == B_DTOUT || b == B_CTOUT || b == B_BLKOVR || b == B_BOOTACK ||
                 b == B_BOOTERR)
            r = RULE_ON_READ;
        else if (b == B_OVERRUN || b == B_UNDERRUN) r = RULE_BY_CFG;
        return r;
    endfunction

endpackage

// File: rtl/sdsr_flag.sv
module sdsr_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q_o <= RST_VAL;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);

    a_r5_clear_without_set: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/sdsr_xfer_fsm.sv
module sdsr_xfer_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic data_end_i,
    input  logic crc_done_i,
    output logic busy_o
);

    typedef enum logic [1:0] {DT_IDLE, DT_DATA, DT_CRC} dt_state_e;

    dt_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DT_IDLE: if (start_i)    state_d = DT_DATA;
            DT_DATA: if (data_end_i) state_d = DT_CRC;
            DT_CRC:  if (crc_done_i) state_d = DT_IDLE;
            default:                 state_d = DT_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            DT_DATA, DT_CRC: busy_o = 1'b1;
            default:         busy_o = 1'b0;
        endcase
    end

    a_r7_start_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    a_r7_crc_end_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DT_CRC && crc_done_i) |=> !busy_o);

endmodule

// File: rtl/sdsr_status_top.sv
module sdsr_status_top
    import sdsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_stb,
    output logic [31:0] rd_data,
    input  logic        cmd_wr,
    input  logic        rdr_rd,
    input  logic        tdr_wr,
    input  logic        cfg_err_clr_on_read,
    input  logic        ev_cmd_sent,
    input  logic        ev_rx_data,
    input  logic        ev_tx_moved,
    input  logic        ev_blk_end,
    input  logic        ev_xfer_start,
    input  logic        ev_data_end,
    input  logic        ev_crc_done,
    input  logic        ev_resp_end,
    input  logic        ev_busy_end,
    input  logic        ev_sdio_irq,
    input  logic        lv_sdio_wait,
    input  logic        ev_cmpl_sig,
    input  logic [4:0]  ev_resp_err,
    input  logic        ev_data_crc_err,
    input  logic        ev_data_tout,
    input  logic        ev_cmpl_tout,
    input  logic        ev_blk_ovr,
    input  logic        lv_fifo_empty,
    input  logic        lv_xfer_idle,
    input  logic        ev_boot_ack,
    input  logic        ev_boot_ack_err,
    input  logic        ev_rx_overrun,
    input  logic        ev_tx_underrun
);

    logic [SR_W-1:0] src_vec;
    logic [SR_W-1:0] word;
    logic            xfer_busy;

    sdsr_xfer_fsm u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (ev_xfer_start),
        .data_end_i (ev_data_end),
        .crc_done_i (ev_crc_done),
        .busy_o     (xfer_busy)
    );

    always_comb begin
        src_vec = '0;
        src_vec[B_CMDRDY]   = ev_cmd_sent;
        src_vec[B_RXRDY]    = ev_rx_data;
        src_vec[B_TXRDY]    = ev_tx_moved;
        src_vec[B_BLKEND]   = ev_blk_end;
        src_vec[B_XFERBUSY] = xfer_busy;
        src_vec[B_NOTBUSY]  = ev_busy_end;
        src_vec[B_SDIOIRQ]  = ev_sdio_irq;
        src_vec[B_SDIOWAIT] = lv_sdio_wait;
        src_vec[B_CMPLSIG]  = ev_cmpl_sig;
        src_vec[B_RESPERR +: RESP_ERR_W] = ev_resp_err;
        src_vec[B_DCRCERR]  = ev_data_crc_err;
        src_vec[B_DTOUT]    = ev_data_tout;
        src_vec[B_CTOUT]    = ev_cmpl_tout;
        src_vec[B_BLKOVR]   = ev_blk_ovr;
        src_vec[B_FIFOEMP]  = lv_fifo_empty;
        src_vec[B_XFRIDLE]  = lv_xfer_idle;
        src_vec[B_BOOTACK]  = ev_boot_ack;
        src_vec[B_BOOTERR]  = ev_boot_ack_err;
        src_vec[B_OVERRUN]  = ev_rx_overrun;
        src_vec[B_UNDERRUN] = ev_tx_underrun;
    end

    for (genvar g = 0; g < SR_W; g++) begin : g_bit
        localparam rule_e RULE = bit_rule(g);
        if (RULE == RULE_RSVD || RULE == RULE_LIVE) begin : g_pass
            assign word[g] = src_vec[g];
        end else begin : g_flag
            logic clr;
            if (RULE == RULE_ON_READ) begin : g_c
                assign clr = rd_stb;
            end else if (RULE == RULE_ON_CMD) begin : g_c
                assign clr = cmd_wr;
            end else if (RULE == RULE_ON_RDR) begin : g_c
                assign clr = rdr_rd;
            end else if (RULE == RULE_ON_TDR) begin : g_c
                assign clr = tdr_wr;
            end else if (RULE == RULE_BY_CFG) begin : g_c
                assign clr = cfg_err_clr_on_read ? rd_stb : cmd_wr;
            end else begin : g_c
                assign clr = ev_resp_end;
            end
            sdsr_flag #(.RST_VAL(RESET_WORD[g])) u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (src_vec[g]),
                .clr_i (clr),
                .q_o   (word[g])
            );
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= word;
    end

    a_r4_resp_err_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
        (word[B_RESPERR] && rd_stb && !cmd_wr) |=> word[B_RESPERR]);

    a_r6_cfg_read_ignores_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err_clr_on_read && word[B_OVERRUN] && cmd_wr && !rd_stb) |=> word[B_OVERRUN]);

    a_r6_cfg_cmd_ignores_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_err_clr_on_read && word[B_UNDERRUN] && rd_stb && !cmd_wr) |=> word[B_UNDERRUN]);

    a_r11_hold_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rd_data[7:6] == 2'b00 && rd_data[11:9] == 3'b000 &&
                    rd_data[15:14] == 2'b00 && !rd_data[29]));

endmodule

// File: tb/test_sdsr_status_top.sv
module test_sdsr_status_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        rd_stb = 0, cmd_wr = 0, rdr_rd = 0, tdr_wr = 0, cfg_err_clr_on_read = 0;
    logic        ev_cmd_sent = 0, ev_rx_data = 0, ev_tx_moved = 0, ev_blk_end = 0;
    logic        ev_xfer_start = 0, ev_data_end = 0, ev_crc_done = 0;
    logic        ev_resp_end = 0, ev_busy_end = 0, ev_sdio_irq = 0, lv_sdio_wait = 0;
    logic        ev_cmpl_sig = 0, ev_data_crc_err = 0, ev_data_tout = 0, ev_cmpl_tout = 0;
    logic        ev_blk_ovr = 0, lv_fifo_empty = 0, lv_xfer_idle = 0;
    logic        ev_boot_ack = 0, ev_boot_ack_err = 0, ev_rx_overrun = 0, ev_tx_underrun = 0;
    logic [4:0]  ev_resp_err = '0;
    logic [31:0] rd_data;

    sdsr_status_top i_sdsr_status_top (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_data(rd_data),
        .cmd_wr(cmd_wr), .rdr_rd(rdr_rd), .tdr_wr(tdr_wr),
        .cfg_err_clr_on_read(cfg_err_clr_on_read),
        .ev_cmd_sent(ev_cmd_sent), .ev_rx_data(ev_rx_data), .ev_tx_moved(ev_tx_moved),
        .ev_blk_end(ev_blk_end), .ev_xfer_start(ev_xfer_start), .ev_data_end(ev_data_end),
        .ev_crc_done(ev_crc_done), .ev_resp_end(ev_resp_end), .ev_busy_end(ev_busy_end),
        .ev_sdio_irq(ev_sdio_irq), .lv_sdio_wait(lv_sdio_wait), .ev_cmpl_sig(ev_cmpl_sig),
        .ev_resp_err(ev_resp_err), .ev_data_crc_err(ev_data_crc_err),
        .ev_data_tout(ev_data_tout), .ev_cmpl_tout(ev_cmpl_tout), .ev_blk_ovr(ev_blk_ovr),
        .lv_fifo_empty(lv_fifo_empty), .lv_xfer_idle(lv_xfer_idle),
        .ev_boot_ack(ev_boot_ack), .ev_boot_ack_err(ev_boot_ack_err),
        .ev_rx_overrun(ev_rx_overrun), .ev_tx_underrun(ev_tx_underrun)
    );

    typedef struct {
        logic [31:0] val;
        logic [31:0] mask;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic [31:0] STICKY_MASK = 32'h19E0_2108;
    localparam logic [31:0] RESP_MASK   = 32'h001F_0000;
    localparam logic [31:0] ERR_MASK    = 32'hC000_0000;

    task automatic tick();
        @(negedge clk);
        rd_stb = 0; cmd_wr = 0; rdr_rd = 0; tdr_wr = 0;
        ev_cmd_sent = 0; ev_rx_data = 0; ev_tx_moved = 0; ev_blk_end = 0;
        ev_xfer_start = 0; ev_data_end = 0; ev_crc_done = 0; ev_resp_end = 0;
        ev_busy_end = 0; ev_sdio_irq = 0; ev_cmpl_sig = 0; ev_resp_err = '0;
        ev_data_crc_err = 0; ev_data_tout = 0; ev_cmpl_tout = 0; ev_blk_ovr = 0;
        ev_boot_ack = 0; ev_boot_ack_err = 0; ev_rx_overrun = 0; ev_tx_underrun = 0;
    endtask

    // driver: strobe a read and push the expected word into the scoreboard
    task automatic rd(input logic [31:0] val, input logic [31:0] mask, input string tag);
        exp_t e;
        e.val = val; e.mask = mask; e.tag = tag;
        sbq.push_back(e);
        rd_stb = 1;
        tick();
    endtask

    // monitor: after each strobed edge, compare the captured word
    initial begin
        forever begin
            @(posedge clk);
            if (rd_stb) begin
                exp_t e;
                @(negedge clk);
                e = sbq.pop_front();
                checks++;
                if ((rd_data & e.mask) !== (e.val & e.mask)) begin
                    failures++;
                    $display("FAIL %s: rd_data=%h expected=%h mask=%h",
                             e.tag, rd_data & e.mask, e.val & e.mask, e.mask);
                end
            end
        end
    end

    task automatic direct(input logic [31:0] val, input logic [31:0] mask, input string tag);
        checks++;
        if ((rd_data & mask) !== (val & mask)) begin
            failures++;
            $display("FAIL %s: rd_data=%h expected=%h mask=%h",
                     tag, rd_data & mask, val & mask, mask);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();

        // R1 / R12: reset word, full mask
        rd(32'h0000_0025, 32'hFFFF_FFFF, "R1 R12 reset word");

        // R2
        cmd_wr = 1; tick();
        rd(32'h0, 32'h1, "R2 cmdrdy cleared by command write");
        ev_cmd_sent = 1; tick();
        rd(32'h1, 32'h1, "R2 cmdrdy set by command sent");

        // R3
        ev_rx_data = 1; tick();
        rd(32'h2, 32'h2, "R3 rxrdy set");
        rd(32'h2, 32'h2, "R3 rxrdy not cleared by status read");
        rdr_rd = 1; tick();
        rd(32'h0, 32'h2, "R3 rxrdy cleared by data read");
        tdr_wr = 1; tick();
        rd(32'h0, 32'h4, "R3 txrdy cleared by data write");
        ev_tx_moved = 1; tick();
        rd(32'h4, 32'h4, "R3 txrdy set after shift");

        // R4
        ev_resp_err = 5'h1F; tick();
        rd(RESP_MASK, RESP_MASK, "R4 response errors set");
        rd(RESP_MASK, RESP_MASK, "R4 response errors survive read");
        cmd_wr = 1; tick();
        rd(32'h0, RESP_MASK, "R4 response errors cleared by command write");
        ev_resp_err = 5'b00100; tick();
        rd(32'h0004_0000, RESP_MASK, "R4 crc7 error alone on bit 18");
        cmd_wr = 1; ev_cmd_sent = 1; tick();

        // R5
        ev_blk_end = 1; ev_sdio_irq = 1; ev_cmpl_sig = 1; ev_data_crc_err = 1;
        ev_data_tout = 1; ev_cmpl_tout = 1; ev_blk_ovr = 1; ev_boot_ack = 1;
        ev_boot_ack_err = 1; tick();
        tick();
        rd(STICKY_MASK, STICKY_MASK, "R5 sticky flags held and returned");
        rd(32'h0, STICKY_MASK, "R5 sticky flags cleared by read");

        // R6 cfg=1
        cfg_err_clr_on_read = 1;
        ev_rx_overrun = 1; ev_tx_underrun = 1; tick();
        cmd_wr = 1; tick();
        rd(ERR_MASK, ERR_MASK, "R6 cfg1 command write ignored");
        rd(32'h0, ERR_MASK, "R6 cfg1 cleared by read");
        // R6 cfg=0
        cfg_err_clr_on_read = 0;
        ev_rx_overrun = 1; ev_tx_underrun = 1; tick();
        rd(ERR_MASK, ERR_MASK, "R6 cfg0 set");
        rd(ERR_MASK, ERR_MASK, "R6 cfg0 read ignored");
        cmd_wr = 1; tick();
        rd(32'h0, ERR_MASK, "R6 cfg0 cleared by command write");
        ev_cmd_sent = 1; tick();

        // R7
        ev_crc_done = 1; tick();
        rd(32'h0, 32'h10, "R7 crc done while idle has no effect");
        ev_xfer_start = 1; tick();
        rd(32'h10, 32'h10, "R7 busy after start");
        ev_data_end = 1; tick();
        rd(32'h10, 32'h10, "R7 busy during crc phase");
        ev_crc_done = 1; tick();
        rd(32'h0, 32'h10, "R7 idle after crc done");

        // R8
        ev_resp_end = 1; tick();
        rd(32'h0, 32'h20, "R8 notbusy cleared by response end");
        ev_busy_end = 1; tick();
        rd(32'h20, 32'h20, "R8 notbusy set by busy end");

        // R9
        lv_sdio_wait = 1; lv_fifo_empty = 1; lv_xfer_idle = 1;
        rd(32'h0600_1000, 32'h0600_1000, "R9 live levels high");
        lv_sdio_wait = 0; lv_fifo_empty = 0; lv_xfer_idle = 0;
        rd(32'h0, 32'h0600_1000, "R9 live levels low");

        // R11: no strobe, word changes, output holds
        lv_fifo_empty = 1;
        tick(); tick();
        direct(32'h0, 32'h0200_0000, "R11 output held without strobe");
        rd(32'h0200_0000, 32'h0200_0000, "R11 next strobe loads new word");
        lv_fifo_empty = 0;

        // R10: set and clear in one cycle
        ev_data_crc_err = 1;
        rd(32'h0, 32'h0020_0000, "R10 read returns value before set");
        rd(32'h0020_0000, 32'h0020_0000, "R10 set won over read clear");
        rd(32'h0, 32'h0020_0000, "R10 cleared by next read");
        cmd_wr = 1; ev_cmd_sent = 1; tick();
        rd(32'h1, 32'h1, "R10 command sent wins over command write");
        ev_rx_data = 1; tick();
        rdr_rd = 1; ev_rx_data = 1; tick();
        rd(32'h2, 32'h2, "R10 receive set wins over data read");
        cfg_err_clr_on_read = 0;
        ev_rx_overrun = 1; cmd_wr = 1; ev_cmd_sent = 1; tick();
        rd(32'h4000_0000, 32'h4000_0000, "R10 overrun set wins over command write");

        tick(); tick();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule